// File: doc/BRIEF.md
# Exception Mask Override Register

This block holds three privileged control bits that let pending asynchronous exceptions get past the interrupt mask bits of the processor status word. There is one bit for IRQ, one for FIQ and one for asynchronous abort. For each exception type the block decides whether a pending request is delivered. It bases that decision on the current security state, a routing bit from the secure configuration register, the status-word mask bit and the stored override bit.

Software reaches the register through a coprocessor-style access port. The port carries a four-field selector (op1, CRn, CRm, op2), a write flag, write data, and privilege and security qualifiers. Reads return data one cycle after the access. A refused access raises a one-cycle undefined-access flag on that same following cycle.

The delivery outputs are combinational from the stored overrides and the live mask, routing, state and pending inputs. Vectoring, priority between exceptions and mode control are left to the surrounding core.

Top module: `exc_mask_ovr`

## Requirements
- R1: After reset all three override bits are 0, and a legal read returns 0x00000000.
- R2: A legal write updates the register on the clock edge that ends the access cycle. A legal write is an access with selector op1=0, CRn=1, CRm=1, op2=3, taken in privileged mode (`acc_priv`=1) and secure state (`sec_state`=1). Bit 8 is stored as the abort override, bit 7 as the IRQ override and bit 6 as the FIQ override. A legal read presents the stored value on `acc_rdata` in the cycle after the access.
- R3: Bits [31:9] and [5:0] of `acc_rdata` are always 0, whatever was written to them.
- R4: An access to the selector made with `acc_priv`=0 or `sec_state`=0 leaves the register unchanged. In the next cycle it returns 0 on `acc_rdata` and drives `acc_undef` high for exactly that one cycle.
- R5: `take_irq` = `pend_irq` AND (NOT `msk_irq` OR (NOT `sec_state` AND `rte_irq` AND IRQ override)).
- R6: `take_fiq` = `pend_fiq` AND (NOT `msk_fiq` OR (NOT `sec_state` AND `rte_fiq` AND FIQ override)).
- R7: `take_abt` = `pend_abt` AND (NOT `msk_abt` OR (NOT `sec_state` AND `rte_abt` AND abort override)).
- R8: In secure state, or when a routing bit is 0, the matching override has no effect: the take output equals pending AND NOT mask.
- R9: An access with any other selector is ignored: no register change, no `acc_undef`, and `acc_rdata` stays 0 in the next cycle.
- R10: Outside the cycle after a legal read, `acc_rdata` is 0 and `acc_undef` is 0 unless R4 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | Selector field op1 |
| acc_crn | input | 4 | Selector field CRn |
| acc_crm | input | 4 | Selector field CRm |
| acc_op2 | input | 3 | Selector field op2 |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged mode |
| sec_state | input | 1 | 1 = secure state |
| acc_rdata | output | 32 | Read data, one cycle after a legal read |
| acc_undef | output | 1 | Refused-access pulse, one cycle after |
| rte_irq | input | 1 | Secure routing bit for IRQ |
| rte_fiq | input | 1 | Secure routing bit for FIQ |
| rte_abt | input | 1 | Secure routing bit for async abort |
| msk_irq | input | 1 | Status-word I mask |
| msk_fiq | input | 1 | Status-word F mask |
| msk_abt | input | 1 | Status-word A mask |
| pend_irq | input | 1 | IRQ pending |
| pend_fiq | input | 1 | FIQ pending |
| pend_abt | input | 1 | Async abort pending |
| take_irq | output | 1 | Deliver IRQ |
| take_fiq | output | 1 | Deliver FIQ |
| take_abt | output | 1 | Deliver async abort |

## Verification
The bench builds the block with its default parameters: a 32-bit word, override positions 8, 7 and 6, and selector 0/1/1/3. With these values the reserved-bit readback and the per-bit field placement can be checked directly against literal words. For three override settings, the bench sweeps every combination of security state, routing, mask and pending inputs. That exercises each path where an override wins or is ignored. Refused accesses and accesses that differ from the selector in only one field are interleaved with legal ones, to show that they leave the stored bits untouched.

// File: rtl/emo_pkg.sv
`timescale 1ns/1ps
package emo_pkg;
   localparam int unsigned N_EXC  = 3;
   localparam int unsigned EX_FIQ = 0;
   localparam int unsigned EX_IRQ = 1;
   localparam int unsigned EX_ABT = 2;

   typedef struct packed {
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } cp_sel_t;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_OK   = 2'd1,
      ACC_DENY = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/emo_access_dec.sv
`timescale 1ns/1ps
module emo_access_dec
   import emo_pkg::*;
#(
   parameter logic [2:0] SEL_OP1 = 3'd0,
   parameter logic [3:0] SEL_CRN = 4'd1,
   parameter logic [3:0] SEL_CRM = 4'd1,
   parameter logic [2:0] SEL_OP2 = 3'd3
) (
   input  logic      valid,
   input  cp_sel_t   sel,
   input  logic      priv,
   input  logic      secure,
   output acc_kind_e kind
);
   localparam cp_sel_t MATCH = '{op1: SEL_OP1, crn: SEL_CRN, crm: SEL_CRM, op2: SEL_OP2};

   logic hit;
   assign hit = valid && (sel == MATCH);

   always_comb begin
      if (!hit)                kind = ACC_NONE;
      else if (priv && secure) kind = ACC_OK;
      else                     kind = ACC_DENY;
   end
endmodule

// File: rtl/emo_store.sv
`timescale 1ns/1ps
module emo_store
   import emo_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned POS_FIQ = 6,
   parameter int unsigned POS_IRQ = 7,
   parameter int unsigned POS_ABT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [N_EXC-1:0]  ovr,
   output logic [DATA_W-1:0] rdata,
   output logic              undef
);
   localparam int unsigned POS [N_EXC] = '{POS_FIQ, POS_IRQ, POS_ABT};

   logic [N_EXC-1:0]  wr_bits;
   logic [DATA_W-1:0] rd_word;

   for (genvar gi = 0; gi < N_EXC; gi++) begin : g_field
      assign wr_bits[gi] = wdata[POS[gi]];
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N_EXC; i++) rd_word[POS[i]] = ovr[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr   <= '0;
         rdata <= '0;
         undef <= 1'b0;
      end else begin
         undef <= (kind == ACC_DENY);
         rdata <= '0;
         if (kind == ACC_OK) begin
            if (wr) ovr   <= wr_bits;
            else    rdata <= rd_word;
         end
      end
   end
endmodule

// File: rtl/emo_gate.sv
`timescale 1ns/1ps
module emo_gate (
   input  logic pend,
   input  logic mask,
   input  logic route,
   input  logic ovr,
   input  logic nonsec,
   output logic take
);
   logic bypass;
   assign bypass = nonsec & route & ovr;
   assign take   = pend & (~mask | bypass);
endmodule

// File: rtl/exc_mask_ovr.sv
`timescale 1ns/1ps
module exc_mask_ovr
   import emo_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned POS_FIQ = 6,
   parameter int unsigned POS_IRQ = 7,
   parameter int unsigned POS_ABT = 8,
   parameter logic [2:0]  SEL_OP1 = 3'd0,
   parameter logic [3:0]  SEL_CRN = 4'd1,
   parameter logic [3:0]  SEL_CRM = 4'd1,
   parameter logic [2:0]  SEL_OP2 = 3'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_op1,
   input  logic [3:0]        acc_crn,
   input  logic [3:0]        acc_crm,
   input  logic [2:0]        acc_op2,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_priv,
   input  logic              sec_state,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_undef,
   input  logic              rte_irq,
   input  logic              rte_fiq,
   input  logic              rte_abt,
   input  logic              msk_irq,
   input  logic              msk_fiq,
   input  logic              msk_abt,
   input  logic              pend_irq,
   input  logic              pend_fiq,
   input  logic              pend_abt,
   output logic              take_irq,
   output logic              take_fiq,
   output logic              take_abt
);
   if (POS_FIQ >= DATA_W || POS_IRQ >= DATA_W || POS_ABT >= DATA_W) begin : g_bad_pos
      $error("exc_mask_ovr: override position outside data word");
   end
   if (POS_FIQ == POS_IRQ || POS_FIQ == POS_ABT || POS_IRQ == POS_ABT) begin : g_dup_pos
      $error("exc_mask_ovr: override positions must differ");
   end

   cp_sel_t          sel;
   acc_kind_e        kind;
   logic [N_EXC-1:0] ovr_q;
   logic [N_EXC-1:0] pend_v, mask_v, route_v, take_v;

   assign sel = '{op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

   emo_access_dec #(
      .SEL_OP1(SEL_OP1), .SEL_CRN(SEL_CRN), .SEL_CRM(SEL_CRM), .SEL_OP2(SEL_OP2)
   ) u_dec (
      .valid (acc_valid),
      .sel   (sel),
      .priv  (acc_priv),
      .secure(sec_state),
      .kind  (kind)
   );

   emo_store #(
      .DATA_W(DATA_W), .POS_FIQ(POS_FIQ), .POS_IRQ(POS_IRQ), .POS_ABT(POS_ABT)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .kind (kind),
      .wr   (acc_write),
      .wdata(acc_wdata),
      .ovr  (ovr_q),
      .rdata(acc_rdata),
      .undef(acc_undef)
   );

   assign pend_v  = {pend_abt, pend_irq, pend_fiq};
   assign mask_v  = {msk_abt,  msk_irq,  msk_fiq};
   assign route_v = {rte_abt,  rte_irq,  rte_fiq};

   for (genvar gi = 0; gi < N_EXC; gi++) begin : g_gate
      emo_gate u_gate (
         .pend  (pend_v[gi]),
         .mask  (mask_v[gi]),
         .route (route_v[gi]),
         .ovr   (ovr_q[gi]),
         .nonsec(~sec_state),
         .take  (take_v[gi])
      );
   end

   assign take_fiq = take_v[EX_FIQ];
   assign take_irq = take_v[EX_IRQ];
   assign take_abt = take_v[EX_ABT];
endmodule

// File: rtl/exc_mask_ovr_chk.sv
`timescale 1ns/1ps
module exc_mask_ovr_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned POS_FIQ = 6,
   parameter int unsigned POS_IRQ = 7,
   parameter int unsigned POS_ABT = 8,
   parameter logic [2:0]  SEL_OP1 = 3'd0,
   parameter logic [3:0]  SEL_CRN = 4'd1,
   parameter logic [3:0]  SEL_CRM = 4'd1,
   parameter logic [2:0]  SEL_OP2 = 3'd3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [2:0]        acc_op1,
   input logic [3:0]        acc_crn,
   input logic [3:0]        acc_crm,
   input logic [2:0]        acc_op2,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              acc_priv,
   input logic              sec_state,
   input logic [DATA_W-1:0] acc_rdata,
   input logic              acc_undef,
   input logic              rte_irq,
   input logic              rte_fiq,
   input logic              rte_abt,
   input logic              msk_irq,
   input logic              msk_fiq,
   input logic              msk_abt,
   input logic              pend_irq,
   input logic              pend_fiq,
   input logic              pend_abt,
   input logic              take_irq,
   input logic              take_fiq,
   input logic              take_abt,
   input logic [2:0]        ovr_q
);
   localparam logic [DATA_W-1:0] LIVE =
      (DATA_W'(1) << POS_FIQ) | (DATA_W'(1) << POS_IRQ) | (DATA_W'(1) << POS_ABT);

   logic match, ok, deny;
   assign match = acc_valid && acc_op1 == SEL_OP1 && acc_crn == SEL_CRN &&
                  acc_crm == SEL_CRM && acc_op2 == SEL_OP2;
   assign ok    = match && acc_priv && sec_state;
   assign deny  = match && !(acc_priv && sec_state);

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && acc_write) |=> (ovr_q[0] == $past(acc_wdata[POS_FIQ]) &&
                             ovr_q[1] == $past(acc_wdata[POS_IRQ]) &&
                             ovr_q[2] == $past(acc_wdata[POS_ABT])));

   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rdata & ~LIVE) == '0);

   a_r4_deny_flags: assert property (@(posedge clk) disable iff (!rst_n)
      deny |=> (acc_undef && acc_rdata == '0 && $stable(ovr_q)));

   a_r9_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !match) |=> (!acc_undef && acc_rdata == '0 && $stable(ovr_q)));

   a_r10_undef_cause: assert property (@(posedge clk) disable iff (!rst_n)
      acc_undef |-> $past(deny));

   a_r5_irq_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_irq && msk_irq && take_irq) |-> (!sec_state && rte_irq && ovr_q[1]));

   a_r6_fiq_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_fiq && msk_fiq && take_fiq) |-> (!sec_state && rte_fiq && ovr_q[0]));

   a_r7_abt_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_abt && msk_abt && take_abt) |-> (!sec_state && rte_abt && ovr_q[2]));

   a_r8_secure_plain: assert property (@(posedge clk) disable iff (!rst_n)
      sec_state |-> (take_irq == (pend_irq && !msk_irq) &&
                     take_fiq == (pend_fiq && !msk_fiq) &&
                     take_abt == (pend_abt && !msk_abt)));
endmodule

bind exc_mask_ovr exc_mask_ovr_chk #(
   .DATA_W(DATA_W), .POS_FIQ(POS_FIQ), .POS_IRQ(POS_IRQ), .POS_ABT(POS_ABT),
   .SEL_OP1(SEL_OP1), .SEL_CRN(SEL_CRN), .SEL_CRM(SEL_CRM), .SEL_OP2(SEL_OP2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
   .acc_wdata(acc_wdata), .acc_priv(acc_priv), .sec_state(sec_state),
   .acc_rdata(acc_rdata), .acc_undef(acc_undef),
   .rte_irq(rte_irq), .rte_fiq(rte_fiq), .rte_abt(rte_abt),
   .msk_irq(msk_irq), .msk_fiq(msk_fiq), .msk_abt(msk_abt),
   .pend_irq(pend_irq), .pend_fiq(pend_fiq), .pend_abt(pend_abt),
   .take_irq(take_irq), .take_fiq(take_fiq), .take_abt(take_abt),
   .ovr_q(ovr_q)
);

// File: tb/exc_mask_ovr_tb.sv
`timescale 1ns/1ps
module exc_mask_ovr_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0, acc_priv = 0, sec_state = 1;
   logic [2:0]  acc_op1 = 0, acc_op2 = 0;
   logic [3:0]  acc_crn = 0, acc_crm = 0;
   logic [31:0] acc_wdata = 0;
   logic [31:0] acc_rdata;
   logic        acc_undef;
   logic rte_irq = 0, rte_fiq = 0, rte_abt = 0;
   logic msk_irq = 0, msk_fiq = 0, msk_abt = 0;
   logic pend_irq = 0, pend_fiq = 0, pend_abt = 0;
   logic take_irq, take_fiq, take_abt;

   int    n_run = 0, n_fail = 0;
   string phase = "R1";

   // behavioural reference state
   bit        m_irq, m_fiq, m_abt;
   bit [31:0] m_rdata;
   bit        m_undef;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_mask_ovr u_dut (.*);

   always @(posedge clk) begin
      bit legal_sel;
      legal_sel = acc_valid && acc_op1 == 0 && acc_crn == 1 && acc_crm == 1 && acc_op2 == 3;
      if (!rst_n) begin
         m_irq = 0; m_fiq = 0; m_abt = 0; m_rdata = 0; m_undef = 0;
      end else begin
         m_rdata = 0;
         m_undef = legal_sel && !(acc_priv && sec_state);
         if (legal_sel && acc_priv && sec_state) begin
            if (acc_write) begin
               m_abt = acc_wdata[8]; m_irq = acc_wdata[7]; m_fiq = acc_wdata[6];
            end else begin
               m_rdata[8] = m_abt; m_rdata[7] = m_irq; m_rdata[6] = m_fiq;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit ns;
      ns = !sec_state;
      chk("rdata R3 R10", acc_rdata, m_rdata);
      chk("undef R4 R10", {31'b0, acc_undef}, {31'b0, m_undef});
      chk("take_irq R5 R8", {31'b0, take_irq},
          {31'b0, pend_irq && (!msk_irq || (ns && rte_irq && m_irq))});
      chk("take_fiq R6 R8", {31'b0, take_fiq},
          {31'b0, pend_fiq && (!msk_fiq || (ns && rte_fiq && m_fiq))});
      chk("take_abt R7 R8", {31'b0, take_abt},
          {31'b0, pend_abt && (!msk_abt || (ns && rte_abt && m_abt))});
   end

   task automatic access(input bit wr, input bit [31:0] d, input bit pv, input bit sc,
                         input bit [2:0] o1 = 0, input bit [3:0] n = 1,
                         input bit [3:0] m = 1, input bit [2:0] o2 = 3);
      @(posedge clk); #2;
      acc_valid = 1; acc_write = wr; acc_wdata = d; acc_priv = pv; sec_state = sc;
      acc_op1 = o1; acc_crn = n; acc_crm = m; acc_op2 = o2;
      @(posedge clk); #2;
      acc_valid = 0; acc_write = 0; acc_priv = 0; sec_state = 1;
      @(posedge clk); #2;
   endtask

   // direct read with literal expectation, sampled in the cycle after the access
   task automatic read_expect(input bit [31:0] exp);
      @(posedge clk); #2;
      acc_valid = 1; acc_write = 0; acc_priv = 1; sec_state = 1;
      acc_op1 = 0; acc_crn = 1; acc_crm = 1; acc_op2 = 3;
      @(posedge clk); #2;
      acc_valid = 0;
      @(negedge clk);
      chk("literal readback", acc_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      phase = "R1";  read_expect(32'h0);
      phase = "R2";  access(1, 32'h0000_01C0, 1, 1); read_expect(32'h0000_01C0);
      access(1, 32'h0000_0080, 1, 1); read_expect(32'h0000_0080);
      access(1, 32'h0000_0140, 1, 1); read_expect(32'h0000_0140);
      phase = "R3";  access(1, 32'hFFFF_FFFF, 1, 1); read_expect(32'h0000_01C0);
      access(1, 32'hFFFF_FE3F, 1, 1); read_expect(32'h0);
      access(1, 32'h0000_01C0, 1, 1);
      phase = "R4";  access(1, 32'h0, 0, 1); read_expect(32'h0000_01C0);
      access(1, 32'h0, 1, 0); read_expect(32'h0000_01C0);
      access(0, 32'h0, 0, 0); access(0, 32'h0, 1, 0); read_expect(32'h0000_01C0);
      phase = "R9";  access(1, 32'h0, 1, 1, 0, 1, 2, 3); access(1, 32'h0, 1, 1, 0, 1, 1, 2);
      access(1, 32'h0, 1, 1, 1, 1, 1, 3); access(0, 32'h0, 0, 0, 0, 2, 1, 3);
      read_expect(32'h0000_01C0);
      phase = "R5 R6 R7 R8";
      for (int v = 0; v < 3; v++) begin
         access(1, (v == 0) ? 32'h0 : (v == 1) ? 32'h1C0 : 32'h0C0, 1, 1);
         for (int c = 0; c < 1024; c++) begin
            @(posedge clk); #2;
            sec_state = c[0];
            {rte_irq, rte_fiq, rte_abt} = c[3:1];
            {msk_irq, msk_fiq, msk_abt} = c[6:4];
            {pend_irq, pend_fiq, pend_abt} = c[9:7];
         end
         @(posedge clk); #2 sec_state = 1;
      end
      repeat (2) @(posedge clk);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule